// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive path of an Ethernet MAC. It decides whether a frame's destination address should be accepted. It keeps a 64-entry table with one bit per entry. Software changes one entry at a time by writing a control word. The index sits in the low six bits of the word, and bit 8 says whether the entry is set or cleared. To fill or empty the whole table, software makes 64 such writes.

When the receive logic presents a 48-bit destination address with a valid strobe, the block folds the address into a 6-bit code. Each bit of the code is the XOR of one address byte. The least significant byte supplies the top bit of the code. Addresses with bit 40 set are group addresses, and the block looks their code up in the table. A unicast address is never matched by this block. A promiscuous input overrides the filter and accepts every frame.

One cycle after the strobe, the block reports the decision as a registered valid/accept pair.

Top module: `mcast_hash_filter`

## Requirements
- R1: After a synchronous active-high reset, every table entry is clear and both res_valid and res_accept are low.
- R2: A write with cfg_we high updates the entry indexed by cfg_wdata[5:0] at the next clock edge. The entry is set when cfg_wdata[8] is 1 and cleared when it is 0. All other cfg_wdata bits have no effect.
- R3: A write changes only the addressed entry; every other entry keeps its value.
- R4: Hash bit (5 - i) equals the XOR of the eight address bits [8i+7:8i], for i = 0 to 5.
- R5: With promiscuous mode off, an address with bit 40 clear is rejected whatever the table holds.
- R6: With promiscuous mode off, an address with bit 40 set is accepted exactly when the table entry at its hash is set.
- R7: With promisc_en high, every strobed address is accepted.
- R8: res_valid is high for exactly the cycle after each da_valid cycle, and res_accept is low whenever res_valid is low.
- R9: When a table write and a lookup happen in the same cycle, the lookup uses the table as it was before that write.
- R10: After 64 writes that set every entry, all group addresses are accepted. After 64 writes that clear every entry, all group addresses are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: index in [5:0], set/clear flag in [8] |
| promisc_en | input | 1 | Accept every frame when high |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address as a 48-bit integer |
| res_valid | output | 1 | Decision valid, one cycle after da_valid |
| res_accept | output | 1 | Frame accepted |

## Verification
A table write takes effect at the edge that samples cfg_we, so a lookup strobed in the next cycle already sees the new entry. A lookup strobed in the same cycle as the write still sees the old entry. The decision for a strobe sampled at an edge is registered at that same edge. The bench therefore drives inputs just after a rising edge and reads res_valid and res_accept one time unit after the following rising edge. The table contents are made visible by sweeping group addresses built to hit each of the 64 codes.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned MHF_ADDR_W    = 48;
  localparam int unsigned MHF_HASH_W    = 6;
  localparam int unsigned MHF_CTRL_W    = 32;
  localparam int unsigned MHF_EN_BIT    = 8;
  localparam int unsigned MHF_GROUP_BIT = 40;

  typedef enum logic [1:0] {
    MHF_REJECT  = 2'b00,
    MHF_HASHHIT = 2'b01,
    MHF_PROMISC = 2'b10
  } mhf_reason_e;
endpackage

// File: rtl/mhf_hash.sv
module mhf_hash #(
  parameter int unsigned ADDR_W = mhf_pkg::MHF_ADDR_W,
  parameter int unsigned HASH_W = mhf_pkg::MHF_HASH_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [HASH_W-1:0] code
);
  localparam int unsigned GRP_W = ADDR_W / HASH_W;

  // group 0 (least significant) lands on the top code bit
  for (genvar g = 0; g < HASH_W; g++) begin : g_fold
    assign code[HASH_W-1-g] = ^addr[g*GRP_W +: GRP_W];
  end
endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter int unsigned HASH_W = mhf_pkg::MHF_HASH_W,
  parameter int unsigned CTRL_W = mhf_pkg::MHF_CTRL_W,
  parameter int unsigned EN_BIT = mhf_pkg::MHF_EN_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic [HASH_W-1:0] rd_idx,
  output logic              rd_bit
);
  localparam int unsigned DEPTH = 1 << HASH_W;

  logic [DEPTH-1:0]  bits_q;
  logic [HASH_W-1:0] wr_idx;
  logic              wr_val;

  assign wr_idx = wdata[HASH_W-1:0];
  assign wr_val = wdata[EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
    end else if (we) begin
      bits_q[wr_idx] <= wr_val;
    end
  end

  // read of the pre-write contents
  assign rd_bit = bits_q[rd_idx];

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(bits_q)); // R3
  AST_ONE_ENTRY_PER_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |=> $countones(bits_q ^ $past(bits_q)) <= 1); // R3
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int unsigned ADDR_W    = mhf_pkg::MHF_ADDR_W,
  parameter int unsigned HASH_W    = mhf_pkg::MHF_HASH_W,
  parameter int unsigned CTRL_W    = mhf_pkg::MHF_CTRL_W,
  parameter int unsigned EN_BIT    = mhf_pkg::MHF_EN_BIT,
  parameter int unsigned GROUP_BIT = mhf_pkg::MHF_GROUP_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              promisc_en,
  input  logic              da_valid,
  input  logic [ADDR_W-1:0] da,
  output logic              res_valid,
  output logic              res_accept
);
  import mhf_pkg::*;

  logic [HASH_W-1:0] code;
  logic              entry;
  mhf_reason_e       reason;

  mhf_hash #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_hash (
    .addr (da),
    .code (code)
  );

  mhf_table #(.HASH_W(HASH_W), .CTRL_W(CTRL_W), .EN_BIT(EN_BIT)) u_table (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rd_idx (code),
    .rd_bit (entry)
  );

  always_comb begin
    if (promisc_en)                 reason = MHF_PROMISC;
    else if (da[GROUP_BIT] && entry) reason = MHF_HASHHIT;
    else                            reason = MHF_REJECT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
    end else begin
      res_valid  <= da_valid;
      res_accept <= da_valid && (reason != MHF_REJECT);
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    da_valid |=> res_valid); // R8
  AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (rst)
    !da_valid |=> !res_valid && !res_accept); // R8
  AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (rst)
    da_valid && promisc_en |=> res_accept); // R7
  AST_UNICAST_BLOCK: assert property (@(posedge clk) disable iff (rst)
    da_valid && !promisc_en && !da[GROUP_BIT] |=> !res_accept); // R5
endmodule

// File: tb/sim_mcast_hash_filter.sv
module sim_mcast_hash_filter;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        promisc_en;
  logic        da_valid;
  logic [47:0] da;
  logic        res_valid;
  logic        res_accept;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] model;

  always #5 clk = ~clk;

  mcast_hash_filter u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .promisc_en(promisc_en), .da_valid(da_valid), .da(da),
    .res_valid(res_valid), .res_accept(res_accept)
  );

  function automatic logic [5:0] ref_code(input logic [47:0] a);
    logic [5:0] c;
    for (int i = 0; i < 6; i++) c[5-i] = ^a[8*i +: 8];
    return c;
  endfunction

  function automatic logic [47:0] addr_for(input logic [5:0] h, input logic grp);
    logic [47:0] a;
    a = {$urandom(), $urandom()};
    a[40] = grp;
    for (int i = 0; i < 6; i++)
      if ((^a[8*i +: 8]) != h[5-i]) a[8*i+7] = ~a[8*i+7];
    return a;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic val, input logic [31:0] junk);
    @(posedge clk); #1;
    cfg_we = 1'b1;
    cfg_wdata = (junk & ~32'h13F) | {23'd0, val, 2'b00, idx};
    @(posedge clk); #1;
    cfg_we = 1'b0;
    model[idx] = val;
  endtask

  task automatic look(input logic [47:0] a, input logic pm, input logic exp, input string tag);
    @(posedge clk); #1;
    da_valid = 1'b1; da = a; promisc_en = pm;
    @(posedge clk); #1;
    da_valid = 1'b0; promisc_en = 1'b0;
    check(res_valid == 1'b1, {tag, " valid"}, res_valid, 1'b1);
    check(res_accept == exp, tag, res_accept, exp);
  endtask

  task automatic scan(input string tag);
    for (int h = 0; h < 64; h++)
      look(addr_for(6'(h), 1'b1), 1'b0, model[h], tag);
  endtask

  task automatic t_reset;
    rst = 1'b1; cfg_we = 0; cfg_wdata = 0; promisc_en = 0; da_valid = 0; da = 0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    model = '0;
    check(res_valid == 0, "R1 res_valid", res_valid, 0);
    check(res_accept == 0, "R1 res_accept", res_accept, 0);
    scan("R1 table clear");
  endtask

  task automatic t_single;
    wr(6'd37, 1'b1, 32'hFFFF_FEC0);
    scan("R2 R3 R6 one entry set");
    wr(6'd37, 1'b0, 32'hA5A5_A4C0);
    scan("R2 R3 clear with junk bits");
    wr(6'd0, 1'b1, 32'h0);
    wr(6'd63, 1'b1, 32'h0);
    scan("R3 R6 edge entries");
  endtask

  task automatic t_hash;
    logic [47:0] a;
    for (int h = 0; h < 64; h++) wr(6'(h), 1'($urandom() & 1), 32'h0);
    for (int k = 0; k < 200; k++) begin
      a = {$urandom(), $urandom()};
      a[40] = 1'b1;
      look(a, 1'b0, model[ref_code(a)], "R4 random hash");
    end
  endtask

  task automatic t_all;
    for (int h = 0; h < 64; h++) wr(6'(h), 1'b1, 32'h0);
    scan("R10 all set");
    for (int k = 0; k < 20; k++)
      look(addr_for(6'($urandom()), 1'b0), 1'b0, 1'b0, "R5 unicast rejected");
    for (int h = 0; h < 64; h++) wr(6'(h), 1'b0, 32'h0);
    scan("R10 all clear");
  endtask

  task automatic t_promisc;
    for (int k = 0; k < 10; k++) begin
      look(addr_for(6'($urandom()), 1'b0), 1'b1, 1'b1, "R7 promisc unicast");
      look(addr_for(6'($urandom()), 1'b1), 1'b1, 1'b1, "R7 promisc group");
    end
  endtask

  task automatic t_timing;
    look(addr_for(6'd5, 1'b1), 1'b1, 1'b1, "R8 strobe");
    @(posedge clk); #1;
    check(res_valid == 0, "R8 valid drops", res_valid, 0);
    check(res_accept == 0, "R8 accept idle", res_accept, 0);
  endtask

  task automatic t_same_cycle;
    logic [47:0] a;
    a = addr_for(6'd22, 1'b1);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = 32'h116;
    da_valid = 1'b1; da = a;
    @(posedge clk); #1;
    cfg_we = 1'b0; da_valid = 1'b0;
    model[22] = 1'b1;
    check(res_accept == 0, "R9 old contents", res_accept, 0);
    look(a, 1'b0, 1'b1, "R9 new contents");
  endtask

  initial begin
    t_reset();
    t_single();
    t_hash();
    t_all();
    t_promisc();
    t_timing();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule